// File: doc/BRIEF.md
# Bias-Agreement Conditional Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each branch is mapped to a one-bit bias entry that remembers the direction it took on its first resolve after reset. A separate table of two-bit saturating counters does not learn the direction itself. It learns whether branches seen under the current global history tend to follow their bias bit. The predicted direction is the bias bit, inverted when the counter says the branch will disagree with it. Two branches that alias onto the same counter and share a bias therefore push the counter the same way, where a plain direction counter would see them pull against each other.

The fetch side presents an address on the predict port and gets the direction back combinationally in the same cycle. When a branch is resolved, the back end presents its address and actual direction on the resolve port. The block then trains the selected counter, fills the bias entry if it is still empty, and shifts the outcome into the global history. The counter table is indexed by the history alone. The bias table is indexed by a field of the address XORed with the history. Predictions and resolves are assumed to stay in program order. There is no speculative history and no repair.

Top module: `bias_agree_predictor`

## Requirements
- R1: After reset, every counter holds 2 (weakly agree), every bias bit is 0 and marked empty, and the history is 0. Every address therefore predicts not-taken (0).
- R2: `pred_taken` follows `pred_pc` in the same cycle. It equals the selected bias bit when the selected counter is 2 or 3, and the inverted bias bit when the counter is 0 or 1. The counter is selected by the history. The bias bit is selected by `pred_pc[PC_SHIFT +: HIST_W]` XOR the history.
- R3: A resolve that selects an empty bias entry writes the actual direction into that entry and marks it filled. That resolve counts as an agreement for the counter update.
- R4: A resolve that selects a filled bias entry leaves the entry's bit unchanged, whatever the outcome.
- R5: On each resolve, the counter selected by the history is incremented when the actual direction equals the bias bit it is judged against, and decremented otherwise. It saturates at 3 and at 0.
- R6: On each resolve, the history shifts left by one bit. The actual direction (1 means taken) enters bit 0 and the oldest bit is dropped.
- R7: When a prediction and a resolve fall in the same cycle, the prediction uses the state from before that resolve. The update is visible from the next cycle on.
- R8: Address bits outside `[PC_SHIFT +: HIST_W]` have no effect on a prediction or on which entries a resolve trains.
- R9: While `res_valid` is low, no counter, bias entry or history bit changes, whatever `res_pc` and `res_taken` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | ADDR_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction for `pred_pc`, 1 = taken |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch, 1 = taken |

## Verification
A lookup and a training update can share a cycle. The lookup must then see the tables and history as they stood before the edge, while the update lands at that edge. The bench provokes this on every resolve by driving a second, independent address on the predict port in the same cycle. It samples `pred_taken` just before the rising edge and compares it with a model that has not yet applied the resolve. After the edge it sweeps every index, with clean and noisy upper and lower address bits, against the updated model.

// File: rtl/bap_pkg.sv
package bap_pkg;

   typedef enum logic [1:0] {
      AGR_STRONG_NO  = 2'd0,
      AGR_WEAK_NO    = 2'd1,
      AGR_WEAK_YES   = 2'd2,
      AGR_STRONG_YES = 2'd3
   } agr_ctr_e;

   localparam agr_ctr_e AGR_RESET = AGR_WEAK_YES;

   // saturating step of an agreement counter
   function automatic logic [1:0] agr_step(input logic [1:0] cur, input logic agree);
      logic [1:0] nxt;
      if (agree) nxt = (cur == 2'd3) ? 2'd3 : cur + 2'd1;
      else       nxt = (cur == 2'd0) ? 2'd0 : cur - 2'd1;
      return nxt;
   endfunction

   // upper bit of the counter decides agree / disagree
   function automatic logic agr_says_yes(input logic [1:0] cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bap_history.sv
module bap_history #(
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist_o
);

   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q <= '0;
      else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
   end

   assign hist_o = hist_q;

   AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(shift_bit)}); // R6

   AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist_q)); // R9

endmodule

// File: rtl/bap_agree_table.sv
module bap_agree_table
   import bap_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] sel_idx,
   output logic [1:0]       sel_ctr,
   input  logic             upd_en,
   input  logic             upd_agree
);

   localparam int DEPTH = 1 << IDX_W;

   logic [1:0] ctr_all [DEPTH];
   logic [1:0] ctr_nxt;

   assign ctr_nxt = agr_step(sel_ctr, upd_agree);

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic [1:0] ent_q;
      logic       ent_we;
      assign ent_we = upd_en && (sel_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ent_q <= AGR_RESET;
         else if (ent_we) ent_q <= ctr_nxt;
      end
      assign ctr_all[e] = ent_q;
   end

   assign sel_ctr = ctr_all[sel_idx];

   AST_CTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_agree && sel_ctr != 2'd3) |=> ctr_all[$past(sel_idx)] == $past(sel_ctr) + 2'd1); // R5

   AST_CTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_agree && sel_ctr != 2'd0) |=> ctr_all[$past(sel_idx)] == $past(sel_ctr) - 2'd1); // R5

   AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_agree && sel_ctr == 2'd3) |=> ctr_all[$past(sel_idx)] == 2'd3); // R5

   AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_agree && sel_ctr == 2'd0) |=> ctr_all[$past(sel_idx)] == 2'd0); // R5

   AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> ctr_all[$past(sel_idx)] == $past(sel_ctr)); // R9

endmodule

// File: rtl/bap_bias_table.sv
module bap_bias_table #(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] look_idx,
   output logic             look_bias,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_en,
   input  logic             upd_dir,
   output logic             upd_ref
);

   localparam int DEPTH = 1 << IDX_W;

   logic bias_all [DEPTH];
   logic full_all [DEPTH];
   logic upd_full;
   logic upd_bias;

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic bit_q;
      logic full_q;
      logic fill_we;
      assign fill_we = upd_en && !full_q && (upd_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q  <= 1'b0;
            full_q <= 1'b0;
         end else if (fill_we) begin
            bit_q  <= upd_dir;
            full_q <= 1'b1;
         end
      end
      assign bias_all[e] = bit_q;
      assign full_all[e] = full_q;
   end

   assign look_bias = bias_all[look_idx];
   assign upd_full  = full_all[upd_idx];
   assign upd_bias  = bias_all[upd_idx];
   // an empty entry is judged against the direction it is about to store
   assign upd_ref   = upd_full ? upd_bias : upd_dir;

   AST_BIAS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_full) |=> full_all[$past(upd_idx)] && bias_all[$past(upd_idx)] == $past(upd_dir)); // R3

   AST_BIAS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_full) |=> full_all[$past(upd_idx)] && bias_all[$past(upd_idx)] == $past(upd_bias)); // R4

   AST_BIAS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> full_all[$past(upd_idx)] == $past(upd_full)); // R9

endmodule

// File: rtl/bias_agree_predictor.sv
module bias_agree_predictor
   import bap_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PC_SHIFT = 2,
   parameter int HIST_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_pc,
   output logic              pred_taken,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_pc,
   input  logic              res_taken
);

   localparam int IDX_W = HIST_W;

   if (HIST_W < 2 || HIST_W > 16) begin : g_bad_hist
      $error("bias_agree_predictor: HIST_W must lie in 2..16");
   end
   if (PC_SHIFT < 0 || PC_SHIFT + HIST_W > ADDR_W) begin : g_bad_field
      $error("bias_agree_predictor: address field exceeds ADDR_W");
   end

   logic [HIST_W-1:0] hist;
   logic [IDX_W-1:0]  look_bidx;
   logic [IDX_W-1:0]  upd_bidx;
   logic [1:0]        cur_ctr;
   logic              look_bias;
   logic              upd_ref;
   logic              upd_agree;
   logic              pc_unused;

   assign pc_unused = ^{pred_pc, res_pc};

   assign look_bidx = pred_pc[PC_SHIFT +: IDX_W] ^ hist;
   assign upd_bidx  = res_pc[PC_SHIFT +: IDX_W] ^ hist;
   assign upd_agree = (res_taken == upd_ref);

   bap_history #(.HIST_W(HIST_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (res_valid),
      .shift_bit (res_taken),
      .hist_o    (hist)
   );

   bap_agree_table #(.IDX_W(IDX_W)) u_agree (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_idx   (hist),
      .sel_ctr   (cur_ctr),
      .upd_en    (res_valid),
      .upd_agree (upd_agree)
   );

   bap_bias_table #(.IDX_W(IDX_W)) u_bias (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_idx  (look_bidx),
      .look_bias (look_bias),
      .upd_idx   (upd_bidx),
      .upd_en    (res_valid),
      .upd_dir   (res_taken),
      .upd_ref   (upd_ref)
   );

   assign pred_taken = agr_says_yes(cur_ctr) ? look_bias : ~look_bias;

   AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(pred_pc) |-> !$isunknown(pred_taken)); // R2

endmodule

// File: tb/bias_agree_predictor_tb.sv
`timescale 1ns/1ps
module bias_agree_predictor_tb;

   localparam int AW = 8;
   localparam int SH = 2;
   localparam int HW = 4;
   localparam int N  = 1 << HW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] pred_pc = '0;
   logic          pred_taken;
   logic          res_valid = 1'b0;
   logic [AW-1:0] res_pc = '0;
   logic          res_taken = 1'b0;

   int n_run = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int      m_ctr  [N];
   bit      m_bias [N];
   bit      m_full [N];
   bit [HW-1:0] m_hist;
   bit [15:0]   lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   bias_agree_predictor #(.ADDR_W(AW), .PC_SHIFT(SH), .HIST_W(HW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
   );

   function automatic bit [15:0] rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr;
   endfunction

   function automatic logic [AW-1:0] mk_pc(input int idx, input bit noisy);
      bit [15:0] r;
      r = noisy ? rnd() : 16'h0;
      return {r[1:0], idx[HW-1:0], r[3:2]};
   endfunction

   function automatic bit m_pred(input logic [AW-1:0] pc);
      int bi;
      bi = int'(pc[SH +: HW] ^ m_hist);
      return (m_ctr[m_hist] >= 2) ? m_bias[bi] : !m_bias[bi];
   endfunction

   function automatic void m_resolve(input logic [AW-1:0] pc, input bit t);
      int bi;
      bit rf;
      bi = int'(pc[SH +: HW] ^ m_hist);
      rf = m_full[bi] ? m_bias[bi] : t;
      if (!m_full[bi]) begin
         m_full[bi] = 1'b1;
         m_bias[bi] = t;
      end
      if (t == rf) m_ctr[m_hist] = (m_ctr[m_hist] < 3) ? m_ctr[m_hist] + 1 : 3;
      else         m_ctr[m_hist] = (m_ctr[m_hist] > 0) ? m_ctr[m_hist] - 1 : 0;
      m_hist = {m_hist[HW-2:0], t};
   endfunction

   task automatic chk(input string tag, input bit act, input bit exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s pc=%h actual=%0b expected=%0b", tag, pred_pc, act, exp);
      end
   endtask

   // resolve one branch; a same-cycle prediction sees the old state
   task automatic resolve(input int idx, input bit t);
      @(negedge clk);
      res_valid = 1'b1;
      res_pc    = mk_pc(idx, 1'b1);
      res_taken = t;
      pred_pc   = mk_pc(int'(rnd() % N), 1'b1);
      #2;
      chk("R7", pred_taken, m_pred(pred_pc));
      @(posedge clk);
      m_resolve(res_pc, t);
   endtask

   // idle cycles with garbage on the resolve port, sweep every index
   task automatic sweep(input string tag);
      for (int p = 0; p < N; p++) begin
         @(negedge clk);
         res_valid = 1'b0;
         res_pc    = rnd()[AW-1:0];
         res_taken = rnd()[0];
         pred_pc   = mk_pc(p, 1'b0);
         #1;
         chk(tag, pred_taken, m_pred(pred_pc));
         pred_pc = mk_pc(p, 1'b1);
         #0.5;
         chk("R8", pred_taken, m_pred(pred_pc));
      end
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_ctr[i] = 2; m_bias[i] = 1'b0; m_full[i] = 1'b0;
      end
      m_hist = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, every index not-taken
      for (int p = 0; p < N; p++) begin
         @(negedge clk);
         pred_pc = mk_pc(p, 1'b1);
         #1;
         chk("R1", pred_taken, 1'b0);
      end

      // R3: fill empty entries with both directions
      resolve(5, 1'b1); resolve(9, 1'b0); resolve(3, 1'b1);
      sweep("R3");

      // R6: known outcome pattern drives the history
      resolve(1, 1'b1); resolve(2, 1'b0); resolve(4, 1'b1); resolve(7, 1'b1);
      sweep("R6");

      // R5: long runs saturate counters up and down
      for (int k = 0; k < 12; k++) resolve(k % 3, 1'b1);
      sweep("R5");
      for (int k = 0; k < 12; k++) resolve(k % 5, 1'b0);
      sweep("R5");
      for (int k = 0; k < 10; k++) resolve(6, 1'b1);
      sweep("R5");

      // R4: opposite outcomes on already-filled entries
      for (int k = 0; k < 16; k++) resolve(k, k[0]);
      for (int k = 0; k < 16; k++) resolve(k, !k[0]);
      sweep("R4");

      // R9: idle cycles with noise on the resolve port
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         res_valid = 1'b0; res_pc = rnd()[AW-1:0]; res_taken = rnd()[0];
      end
      sweep("R9");

      // R2: pseudo-random streams, biased and unbiased
      for (int s = 0; s < 400; s++) begin
         int idx;
         bit t;
         idx = int'(rnd() % N);
         t   = (s < 200) ? (idx[0] ^ (rnd()[2:0] == 3'd0)) : rnd()[0];
         resolve(idx, t);
         if (s % 10 == 9) sweep("R2");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

endmodule